// File: doc/BRIEF.md
# Instruction Queue Doorbell and Error Control

This block is the per-queue control point of a command-processing engine. Software rings a doorbell by writing a count of 64-bit instruction words, and the block keeps the running total of words not yet taken. The fetch side takes instructions through a consume handshake, eight words at a time. Each accepted take also raises an in-flight count, and a completion pulse from the engine lowers it again.

The block also holds the queue enable, a continue-on-error control bit, a five-bit interrupt status register and a matching interrupt enable register. Status bits are set by event inputs from the fetch, result and engine paths, and by the block's own doorbell overflow. A subset of these events turns the queue off unless continue-on-error is set. Software reaches all of the state through a single-cycle register port. Reads are combinational on the address, and a write takes effect at the next clock edge.

Register map (address on `reg_addr`): 0 doorbell/pending count, 1 control (bit 0 queue enable, bit 1 continue-on-error), 2 status (write one to clear), 3 status set alias, 4 interrupt enable (write one to set), 5 in-flight count (read only). Status and enable bits: 0 mailbox, 1 doorbell overflow, 2 instruction read error, 3 result write error, 4 engine software error.

Top module: `iqd_ctrl`

## Requirements
- R1: After reset the pending count, control bits, status, interrupt enables and in-flight count all read zero, and `take_ack`, `irq` and `proto_err` are low.
- R2: A write to address 0 adds `reg_wdata[19:0]` to the 20-bit pending count, modulo 2^20. A read of address 0 returns the pending count.
- R3: A doorbell write whose value has any of bits [2:0] set drives `proto_err` high for exactly the one cycle after the write. The value is still added.
- R4: When the doorbell addition carries out of 20 bits, status bit 1 is set.
- R5: A write to address 2 clears every status bit written as 1. An event that sets a bit in the same cycle wins over the clear. Address 2 reads the status.
- R6: A write to address 3 ORs `reg_wdata[4:0]` into the status. Address 3 reads the status.
- R7: A write to address 4 ORs `reg_wdata[4:0]` into the interrupt enables. Zero bits have no effect, and enables never clear except by reset. Address 4 reads them.
- R8: `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: With continue-on-error 0, any setting of status bit 1, 2 or 3, from an event or from the set alias, clears the queue enable. This overrides a control write in the same cycle. Bits 0 and 4 never clear it. `queue_en` shows the enable.
- R10: With continue-on-error 1, errors are still recorded in the status, and the queue enable keeps its value.
- R11: `take_ack` equals `take_req` while the queue is enabled and the pending count is at least 8. An accepted take lowers the pending count by 8, combined with any doorbell write in the same cycle.
- R12: The 8-bit in-flight count rises on an accepted take and falls on `done_evt`. It is unchanged when both happen together, it holds at 0 and at 255, and it reads at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| take_req | input | 1 | Fetch side requests one 8-word instruction |
| take_ack | output | 1 | Take accepted this cycle |
| done_evt | input | 1 | One instruction has completed |
| mbox_evt | input | 1 | Mailbox event, sets status bit 0 |
| ird_err | input | 1 | Instruction read error, sets status bit 2 |
| nwr_err | input | 1 | Result write error, sets status bit 3 |
| sw_err | input | 1 | Engine software error, sets status bit 4 |
| queue_en | output | 1 | Queue enable bit |
| proto_err | output | 1 | One-cycle pulse for a doorbell value that is not a multiple of 8 |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pending count shows up in the very next cycle, both in the address 0 readback and in `take_ack` once the count crosses 8. A lost or stuck status bit appears through `irq` in the same cycle that its enable is set. A queue enable that fails to drop after an error keeps accepting takes, which the reference model flags on the next request. A wrong in-flight count is caught only when address 5 is read, so the bench varies the read address on every cycle to keep that delay short.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
    localparam int ADDR_W = 3;
    localparam int ST_W   = 5;

    localparam int B_MBOX = 0;
    localparam int B_DOVF = 1;
    localparam int B_IRDE = 2;
    localparam int B_NWRE = 3;
    localparam int B_SWER = 4;

    // status causes that stop the queue when continue-on-error is off
    localparam logic [ST_W-1:0] KILL_MASK = (ST_W'(1) << B_DOVF) | (ST_W'(1) << B_IRDE) | (ST_W'(1) << B_NWRE);

    typedef enum logic [ADDR_W-1:0] {
        A_DBELL = 3'd0,
        A_CTRL  = 3'd1,
        A_STAT  = 3'd2,
        A_SSET  = 3'd3,
        A_IENA  = 3'd4,
        A_INFL  = 3'd5
    } addr_e;
endpackage

// File: rtl/iqd_doorbell.sv
module iqd_doorbell #(
    parameter int CNT_W      = 20,
    parameter int INSN_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_vld,
    input  logic [CNT_W-1:0] add_val,
    input  logic             take_req,
    input  logic             q_en,
    output logic             take_ack,
    output logic             ovf,
    output logic [CNT_W-1:0] pending,
    output logic             proto_err
);
    localparam logic [CNT_W-1:0] GRAN = CNT_W'(INSN_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             proto;
    } db_t;

    db_t s_d, s_q;
    logic [CNT_W:0] sum;

    always_comb begin
        take_ack = take_req && q_en && (s_q.cnt >= GRAN);
        sum      = {1'b0, s_q.cnt} + (add_vld ? {1'b0, add_val} : '0);
        ovf      = sum[CNT_W];
        s_d.cnt   = sum[CNT_W-1:0] - (take_ack ? GRAN : '0);
        s_d.proto = add_vld && ((add_val & (GRAN - 1'b1)) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending   = s_q.cnt;
    assign proto_err = s_q.proto;

    p_db_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_vld && !take_ack) |=> (s_q.cnt == $past(s_q.cnt) + $past(add_val)));
    p_proto_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (add_vld && add_val[0]) |=> proto_err);
    p_take_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && !add_vld) |=> (s_q.cnt == $past(s_q.cnt) - GRAN));
endmodule

// File: rtl/iqd_events.sv
module iqd_events
    import iqd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [1:0]      ctl_bits,
    input  logic            clr_wr,
    input  logic            set_wr,
    input  logic            ien_wr,
    input  logic [ST_W-1:0] wbits,
    input  logic [ST_W-1:0] hw_set,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] ien,
    output logic            q_en,
    output logic            cont_err,
    output logic            irq
);
    typedef struct packed {
        logic [ST_W-1:0] st;
        logic [ST_W-1:0] ien;
        logic            en;
        logic            ce;
    } ev_t;

    ev_t s_d, s_q;
    logic [ST_W-1:0] set_v, clr_v;

    always_comb begin
        set_v = hw_set | (set_wr ? wbits : '0);
        clr_v = clr_wr ? wbits : '0;
        s_d     = s_q;
        s_d.st  = (s_q.st & ~clr_v) | set_v;
        s_d.ien = s_q.ien | (ien_wr ? wbits : '0);
        if (ctl_wr) begin
            s_d.en = ctl_bits[0];
            s_d.ce = ctl_bits[1];
        end
        if (!s_q.ce && ((set_v & KILL_MASK) != '0)) s_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status   = s_q.st;
    assign ien      = s_q.ien;
    assign q_en     = s_q.en;
    assign cont_err = s_q.ce;
    assign irq      = |(s_q.st & s_q.ien);

    p_ien_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.ien & $past(s_q.ien)) == $past(s_q.ien)));
    p_err_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ce && ((hw_set & KILL_MASK) != '0)) |=> !s_q.en);
    p_cont_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ce && s_q.en && !ctl_wr) |=> s_q.en);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[B_NWRE] |=> status[B_NWRE]);
endmodule

// File: rtl/iqd_inflight.sv
module iqd_inflight #(
    parameter int INF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [INF_W-1:0] cnt
);
    localparam logic [INF_W-1:0] TOP = '1;

    logic [INF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != TOP)     cnt_d = cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_inf_dec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_inf_floor_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/iqd_ctrl.sv
module iqd_ctrl
    import iqd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    parameter int INF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              take_req,
    output logic              take_ack,
    input  logic              done_evt,
    input  logic              mbox_evt,
    input  logic              ird_err,
    input  logic              nwr_err,
    input  logic              sw_err,
    output logic              queue_en,
    output logic              proto_err,
    output logic              irq
);
    logic [CNT_W-1:0] pending;
    logic [INF_W-1:0] inflight;
    logic [ST_W-1:0]  status, ien, hw_set;
    logic             ovf, cont_err;
    logic             wr_db, wr_ctl, wr_clr, wr_set, wr_ien;

    always_comb begin
        wr_db  = reg_wr && (reg_addr == A_DBELL);
        wr_ctl = reg_wr && (reg_addr == A_CTRL);
        wr_clr = reg_wr && (reg_addr == A_STAT);
        wr_set = reg_wr && (reg_addr == A_SSET);
        wr_ien = reg_wr && (reg_addr == A_IENA);
        hw_set = '0;
        hw_set[B_MBOX] = mbox_evt;
        hw_set[B_DOVF] = ovf;
        hw_set[B_IRDE] = ird_err;
        hw_set[B_NWRE] = nwr_err;
        hw_set[B_SWER] = sw_err;
    end

    iqd_doorbell #(.CNT_W(CNT_W), .INSN_WORDS(8)) u_db (
        .clk(clk), .rst_n(rst_n),
        .add_vld(wr_db), .add_val(reg_wdata[CNT_W-1:0]),
        .take_req(take_req), .q_en(queue_en),
        .take_ack(take_ack), .ovf(ovf),
        .pending(pending), .proto_err(proto_err)
    );

    iqd_events u_ev (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(wr_ctl), .ctl_bits(reg_wdata[1:0]),
        .clr_wr(wr_clr), .set_wr(wr_set), .ien_wr(wr_ien),
        .wbits(reg_wdata[ST_W-1:0]), .hw_set(hw_set),
        .status(status), .ien(ien), .q_en(queue_en),
        .cont_err(cont_err), .irq(irq)
    );

    iqd_inflight #(.INF_W(INF_W)) u_inf (
        .clk(clk), .rst_n(rst_n),
        .inc(take_ack), .dec(done_evt), .cnt(inflight)
    );

    always_comb begin
        case (reg_addr)
            A_DBELL:        reg_rdata = DATA_W'(pending);
            A_CTRL:         reg_rdata = DATA_W'({cont_err, queue_en});
            A_STAT, A_SSET: reg_rdata = DATA_W'(status);
            A_IENA:         reg_rdata = DATA_W'(ien);
            A_INFL:         reg_rdata = DATA_W'(inflight);
            default:        reg_rdata = '0;
        endcase
    end

    p_no_take_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_en) |-> !take_ack);
    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: tb/tb_iqd_ctrl.sv
module tb_iqd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take_req = 1'b0, take_ack, done_evt = 1'b0;
    logic        mbox_evt = 1'b0, ird_err = 1'b0, nwr_err = 1'b0, sw_err = 1'b0;
    logic        queue_en, proto_err, irq;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_cnt = 0, m_inf = 0, m_st = 0, m_ie = 0;
    bit m_en = 0, m_ce = 0, m_proto = 0;

    always #4 clk = ~clk;

    iqd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take_req(take_req),
        .take_ack(take_ack), .done_evt(done_evt), .mbox_evt(mbox_evt),
        .ird_err(ird_err), .nwr_err(nwr_err), .sw_err(sw_err),
        .queue_en(queue_en), .proto_err(proto_err), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return {m_ce, m_en};
            3'd2, 3'd3: return m_st;
            3'd4: return m_ie;
            3'd5: return m_inf;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2 pending readback";
            3'd1: return "R9 R10 control readback";
            3'd2: return "R5 R4 status readback";
            3'd3: return "R6 status alias readback";
            3'd4: return "R7 interrupt enable readback";
            3'd5: return "R12 in-flight readback";
            default: return "R2 unmapped readback";
        endcase
    endfunction

    // compare outputs, advance model and design by one clock
    task automatic tick();
        bit ack, ovf, kill;
        int add, sum, setv, clrv;
        #1;
        ack = take_req && m_en && (m_cnt >= 8);
        check(take_ack, ack, "R11 take_ack");
        check(irq, ((m_st & m_ie) != 0), "R8 irq");
        check(proto_err, m_proto, "R3 proto_err");
        check(queue_en, m_en, "R9 R10 queue_en");
        check(reg_rdata, m_read(reg_addr), rd_tag(reg_addr));
        add  = (reg_wr && reg_addr == 3'd0) ? int'(reg_wdata[19:0]) : 0;
        sum  = m_cnt + add;
        ovf  = sum >= (1 << 20);
        setv = {sw_err, nwr_err, ird_err, ovf, mbox_evt};
        if (reg_wr && reg_addr == 3'd3) setv |= int'(reg_wdata[4:0]);
        clrv = (reg_wr && reg_addr == 3'd2) ? int'(reg_wdata[4:0]) : 0;
        kill = !m_ce && ((setv & 'b01110) != 0);
        m_proto = (reg_wr && reg_addr == 3'd0 && reg_wdata[2:0] != 3'd0);
        m_cnt = (sum - (ack ? 8 : 0)) & 'hFFFFF;
        m_st  = (m_st & ~clrv) | setv;
        if (reg_wr && reg_addr == 3'd4) m_ie |= int'(reg_wdata[4:0]);
        if (reg_wr && reg_addr == 3'd1) begin
            m_en = reg_wdata[0];
            m_ce = reg_wdata[1];
        end
        if (kill) m_en = 0;
        if (ack && !done_evt && m_inf != 255) m_inf++;
        else if (done_evt && !ack && m_inf != 0) m_inf--;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 0; take_req = 0; done_evt = 0;
        mbox_evt = 0; ird_err = 0; nwr_err = 0; sw_err = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        idle();
    endtask

    task automatic rd(input logic [2:0] a);
        idle(); reg_addr = a;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        for (int a = 0; a < 6; a++) begin
            reg_addr = 3'(a); #1;
            check(reg_rdata, 0, "R1 reset readback");
        end
        check({take_ack, irq, proto_err, queue_en}, 0, "R1 reset outputs");
        rd(3'd0);

        // R2 doorbell accumulation, R11 takes
        wr(3'd0, 32'd24);
        rd(3'd0);
        check(reg_rdata, 24, "R2 doorbell sum");
        idle(); take_req = 1; tick();            // disabled: no take
        wr(3'd1, 32'd1);
        idle(); take_req = 1; reg_addr = 3'd5; tick(); tick(); tick(); tick();
        rd(3'd0);
        check(reg_rdata, 0, "R11 drained to zero");
        // R12 done saturating at zero
        idle(); done_evt = 1; reg_addr = 3'd5; tick(); tick(); tick(); tick();
        // R11 write and take in one cycle
        wr(3'd0, 32'd8);
        idle(); reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'd16; take_req = 1; tick();
        rd(3'd0);
        check(reg_rdata, 16, "R11 write plus take");

        // R3 misaligned doorbell
        wr(3'd0, 32'd5);
        check(proto_err, 1, "R3 pulse after misaligned write");
        rd(3'd0);
        check(proto_err, 0, "R3 pulse lasts one cycle");

        // R7 write-one-to-set enables
        wr(3'd4, 32'h3);
        wr(3'd4, 32'h0);
        rd(3'd4);
        check(reg_rdata, 3, "R7 zero write keeps enables");

        // R4 overflow kills queue (R9), raises irq (R8)
        wr(3'd0, 32'hFFFF8);
        wr(3'd0, 32'h10);
        rd(3'd2);
        check(reg_rdata[1], 1, "R4 overflow status bit");
        check(queue_en, 0, "R9 overflow clears enable");
        check(irq, 1, "R8 irq on enabled status");

        // R5 clear, with set winning in the same cycle
        idle(); reg_wr = 1; reg_addr = 3'd2; reg_wdata = 32'h1F; mbox_evt = 1; tick();
        rd(3'd2);
        check(reg_rdata, 1, "R5 set wins over clear");
        wr(3'd2, 32'h1);

        // R10 continue-on-error keeps enable
        wr(3'd1, 32'd3);
        idle(); nwr_err = 1; tick();
        idle(); ird_err = 1; tick();
        rd(3'd2);
        check(queue_en, 1, "R10 enable kept");
        check(reg_rdata, 32'hC, "R10 errors recorded");

        // R6 alias set kills with continue-on-error off; R9 error beats enable write
        wr(3'd1, 32'd1);
        wr(3'd3, 32'h4);
        check(queue_en, 0, "R6 R9 alias set clears enable");
        idle(); reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'd1; nwr_err = 1; tick();
        check(queue_en, 0, "R9 error beats enable write");
        wr(3'd1, 32'd1);
        idle(); mbox_evt = 1; sw_err = 1; tick();
        check(queue_en, 1, "R9 mailbox and sw error keep enable");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            idle();
            reg_addr = 3'($urandom_range(0, 6));
            if ($urandom_range(0, 3) == 0) begin
                reg_wr = 1;
                case (reg_addr)
                    3'd0: reg_wdata = ($urandom_range(0, 15) == 0) ? $urandom : 32'($urandom_range(0, 4) * 8);
                    3'd1: reg_wdata = ($urandom_range(0, 3) == 0) ? 32'd3 : 32'd1;
                    3'd2: reg_wdata = 32'($urandom_range(0, 31));
                    3'd3, 3'd4: reg_wdata = ($urandom_range(0, 7) == 0) ? 32'($urandom_range(0, 31)) : 32'd0;
                    default: reg_wdata = $urandom;
                endcase
            end
            take_req = $urandom_range(0, 1) == 1;
            done_evt = $urandom_range(0, 2) == 0;
            mbox_evt = $urandom_range(0, 60) == 0;
            ird_err  = $urandom_range(0, 60) == 0;
            nwr_err  = $urandom_range(0, 60) == 0;
            sw_err   = $urandom_range(0, 60) == 0;
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule